// File: doc/BRIEF.md
# Auto-Increment Serial Flash Programming Sequencer

This block sits on the host side of a serial flash and writes a run of consecutive bytes using the flash's auto-address-increment program method. The caller gives a 24-bit start address and a byte count, pulses `start`, and then hands over the bytes one at a time on a valid/ready stream. The block acts as an SPI master in mode 0. It sends write-enable, then a first program frame that carries the address and the first byte. After that it sends a short program frame for each further byte. Between frames it waits for the flash's internal write to finish.

The wait is set by `use_poll`. With polling on, the block reads the status register after every program frame and repeats the read until the busy bit clears. With polling off, it holds the chip select high for a fixed number of clock cycles instead. After the last byte it sends write-disable, waits once more, and then pulses `done`. A watchdog guards the busy wait. If the flash stays busy too long, the block sets `err`, sends write-disable and finishes. The target range must already be erased. This block does no erasing, no blank check and no read-back.

Top module: `aai_prog_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are `ce_n`=1, `sck`=0, `done`=0, `err`=0, `in_ready`=0 and `active`=0. Chip select stays high whenever the sequencer is idle.
- R2: Before any program frame, the block sends the single byte 0x06 alone, inside its own chip-select frame.
- R3: The first program frame is 0xAF, then address bits 23:16, 15:8 and 7:0, then the first data byte: five bytes, each sent most significant bit first.
- R4: Each later program frame is exactly two bytes: 0xAF followed by the next data byte, with no address.
- R5: With `use_poll`=1, each program frame is followed by status frames of two bytes each (0x05, then a dummy 0x00). The status byte is the one received on SO during the second byte, and bit 0 of it is the busy flag. The block repeats these frames while bit 0 reads 1, and starts the next frame only once a status with bit 0 = 0 has been read.
- R6: With `use_poll`=0, no status frames are sent. Chip select stays high for at least TBP_CYC clock cycles after each program frame, and after the write-disable frame before `done`.
- R7: After the last data byte's wait, the block sends the single-byte frame 0x04 and waits again in the selected way. Then `done` pulses high for exactly one cycle.
- R8: A start with a byte count of zero raises `done` on the next cycle, and chip select never goes low.
- R9: If busy is still read as 1 at the end of a status frame that ends at least TMO_CYC cycles after the program or write-disable frame, the block does the following. It sets `err`, sends 0x04 if it has not yet done so, and pulses `done`. `err` stays set until the next start.
- R10: SCK idles low. Its period is 2*(`clk_div`+1) clock cycles. SI changes only while SCK is low and is stable across every rising edge. SO is sampled on the rising edge.
- R11: `in_ready` is high only while the block waits for a data byte inside an open program frame. A byte is taken on a cycle with `in_valid` and `in_ready` both high. While the block waits, chip select stays low and `in_ready` holds.
- R12: Chip select stays high for at least GAP_CYC clock cycles between any two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| use_poll | input | 1 | 1: poll status between frames, 0: fixed wait |
| clk_div | input | DIV_W | SCK half period minus one, in clock cycles |
| start_addr | input | 24 | First flash address |
| byte_cnt | input | CNT_W | Number of bytes to program |
| in_data | input | 8 | Data byte stream |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Sequencer accepts a data byte |
| sck | output | 1 | SPI clock, mode 0 |
| ce_n | output | 1 | SPI chip select, active low |
| si | output | 1 | Serial data to flash |
| so | input | 1 | Serial data from flash |
| active | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy-wait timeout occurred |

## Verification
Some rules are checked on every cycle. SI stays stable across each rising SCK edge. Chip select is high whenever the block is idle and stays high for more than one cycle after each frame. `in_ready` appears only inside an open frame and holds while the stream stalls. `done` is a single-cycle pulse, a zero count completes on the next cycle, and `err` holds until a new start. Other behaviour is only visible across a whole exchange with a modelled flash, so the bench's scenarios show it. This covers the exact byte content and order of every frame, the number of status reads for a given busy time, the fixed-wait and inter-frame gap lengths, the SCK period, and the abort path taken after a timeout.

// File: rtl/aai_pkg.sv
package aai_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_PROG, ST_WRDI, ST_POLL, ST_GAP, ST_FIXW, ST_DONE
  } aai_st_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_AAI   = 8'hAF;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_DUMMY = 8'h00;
endpackage

// File: rtl/aai_tick_cnt.sv
module aai_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (en && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/aai_spi_byte.sv
module aai_spi_byte #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             go,
  input  logic [7:0]       tx,
  input  logic             so,
  output logic             sck,
  output logic             si,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx
);
  logic             act_q, act_d;
  logic             sck_q, sck_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;
  logic [DIV_W-1:0] hc_q, hc_d;
  logic [2:0]       bit_q, bit_d;
  logic             done_q, done_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    hc_d   = hc_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        sck_d = 1'b0;
        sh_d  = tx;
        hc_d  = '0;
        bit_d = '0;
      end
    end else if (hc_q == div) begin
      hc_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], so};
      end else begin
        sck_d = 1'b0;
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      hc_d = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      hc_q   <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      if (act_d || go) begin
        sh_q  <= sh_d;
        rx_q  <= rx_d;
        hc_q  <= hc_d;
        bit_q <= bit_d;
      end
    end
  end

  assign sck  = sck_q;
  assign si   = sh_q[7];
  assign busy = act_q;
  assign done = done_q;
  assign rx   = rx_q;

  // R10: data out must not move on the sampling edge
  p_si_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(si));
  // R10: clock returns low when a byte completes
  p_sck_low_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sck);
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
  import aai_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4,
  parameter int TBP_CYC = 300,
  parameter int TMO_CYC = 4000,
  parameter int TMR_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_poll,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [23:0]      start_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             sck,
  output logic             ce_n,
  output logic             si,
  input  logic             so,
  output logic             active,
  output logic             done,
  output logic             err
);
  localparam logic [TMR_W-1:0] GAP_END = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] TBP_END = TMR_W'(TBP_CYC - 1);
  localparam logic [TMR_W-1:0] TMO_LIM = TMR_W'(TMO_CYC);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  aai_st_e          st_q, st_d, after_q, after_d, tgt_q, tgt_d;
  logic [23:0]      addr_q, addr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             poll_q, poll_d, first_q, first_d;
  logic             err_q, err_d, xfer_q, xfer_d, ce_n_q, ce_n_d;
  logic [2:0]       bidx_q, bidx_d, last_idx;
  logic [7:0]       cmd_byte, tx;
  logic             frame_st, next_frame, need_data, go, fr_end, tmo_clr, tmo_hit;
  logic             sh_busy, sh_done;
  logic [7:0]       sh_rx;
  logic [TMR_W-1:0] gcnt, tcnt;

  aai_spi_byte #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .div(clk_div), .go(go), .tx(tx), .so(so),
    .sck(sck), .si(si), .busy(sh_busy), .done(sh_done), .rx(sh_rx)
  );

  aai_tick_cnt #(.W(TMR_W)) u_state_tmr (
    .clk(clk), .rst_n(rst_i_n), .clr(st_d != st_q), .en(1'b1), .cnt(gcnt)
  );

  aai_tick_cnt #(.W(TMR_W)) u_busy_tmr (
    .clk(clk), .rst_n(rst_i_n), .clr(tmo_clr), .en(1'b1), .cnt(tcnt)
  );

  assign frame_st   = (st_q == ST_WREN) || (st_q == ST_PROG) ||
                      (st_q == ST_WRDI) || (st_q == ST_POLL);
  assign next_frame = (st_d == ST_WREN) || (st_d == ST_PROG) ||
                      (st_d == ST_WRDI) || (st_d == ST_POLL);

  always_comb begin
    case (st_q)
      ST_PROG: last_idx = first_q ? 3'd4 : 3'd1;
      ST_POLL: last_idx = 3'd1;
      default: last_idx = 3'd0;
    endcase
  end

  always_comb begin
    cmd_byte = OP_DUMMY;
    case (st_q)
      ST_WREN: cmd_byte = OP_WREN;
      ST_WRDI: cmd_byte = OP_WRDI;
      ST_POLL: cmd_byte = (bidx_q == 3'd0) ? OP_RDSR : OP_DUMMY;
      ST_PROG: begin
        case (bidx_q)
          3'd0:    cmd_byte = OP_AAI;
          3'd1:    cmd_byte = addr_q[23:16];
          3'd2:    cmd_byte = addr_q[15:8];
          3'd3:    cmd_byte = addr_q[7:0];
          default: cmd_byte = OP_DUMMY;
        endcase
      end
      default: cmd_byte = OP_DUMMY;
    endcase
  end

  assign need_data = (st_q == ST_PROG) && (bidx_q == last_idx);
  assign in_ready  = need_data && !xfer_q;
  assign go        = frame_st && !xfer_q && !sh_busy && (!need_data || in_valid);
  assign tx        = need_data ? in_data : cmd_byte;
  assign fr_end    = sh_done && (bidx_q == last_idx);
  assign tmo_hit   = tcnt >= TMO_LIM;

  always_comb begin
    st_d    = st_q;
    after_d = after_q;
    tgt_d   = tgt_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    poll_d  = poll_q;
    first_d = first_q;
    err_d   = err_q;
    tmo_clr = 1'b0;
    xfer_d  = go ? 1'b1 : (sh_done ? 1'b0 : xfer_q);
    bidx_d  = sh_done ? (fr_end ? 3'd0 : bidx_q + 3'd1) : bidx_q;
    case (st_q)
      ST_IDLE: if (start) begin
        err_d   = 1'b0;
        addr_d  = start_addr;
        rem_d   = byte_cnt;
        poll_d  = use_poll;
        first_d = 1'b1;
        st_d    = (byte_cnt == '0) ? ST_DONE : ST_WREN;
      end
      ST_WREN: if (fr_end) begin
        after_d = ST_PROG;
        st_d    = ST_GAP;
      end
      ST_PROG: if (fr_end) begin
        rem_d   = rem_q - 1'b1;
        first_d = 1'b0;
        tgt_d   = (rem_q == CNT_W'(1)) ? ST_WRDI : ST_PROG;
        after_d = poll_q ? ST_POLL : ST_FIXW;
        tmo_clr = 1'b1;
        st_d    = ST_GAP;
      end
      ST_WRDI: if (fr_end) begin
        st_d = ST_GAP;
        if (err_q) after_d = ST_DONE;
        else begin
          tgt_d   = ST_DONE;
          after_d = poll_q ? ST_POLL : ST_FIXW;
          tmo_clr = 1'b1;
        end
      end
      ST_POLL: if (fr_end) begin
        st_d = ST_GAP;
        if (!sh_rx[0]) after_d = tgt_q;
        else if (tmo_hit) begin
          err_d   = 1'b1;
          after_d = (tgt_q == ST_DONE) ? ST_DONE : ST_WRDI;
        end else after_d = ST_POLL;
      end
      ST_GAP:  if (gcnt >= GAP_END) st_d = after_q;
      ST_FIXW: if (gcnt >= TBP_END) st_d = tgt_q;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    ce_n_d = !next_frame;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      after_q <= ST_IDLE;
      tgt_q   <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      poll_q  <= 1'b0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      xfer_q  <= 1'b0;
      bidx_q  <= '0;
      ce_n_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      after_q <= after_d;
      tgt_q   <= tgt_d;
      err_q   <= err_d;
      xfer_q  <= xfer_d;
      bidx_q  <= bidx_d;
      ce_n_q  <= ce_n_d;
      if (st_q == ST_IDLE) begin
        addr_q <= addr_d;
        poll_q <= poll_d;
      end
      if (fr_end || st_q == ST_IDLE) begin
        rem_q   <= rem_d;
        first_q <= first_d;
      end
    end
  end

  assign ce_n   = ce_n_q;
  assign active = (st_q != ST_IDLE);
  assign done   = (st_q == ST_DONE);
  assign err    = err_q;

  // R1: no chip select while idle
  p_idle_ce_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_IDLE) |-> ce_n);
  // R11: data is requested only inside an open frame
  p_ready_ce_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_ready |-> !ce_n);
  // R11: a stalled request holds with the clock parked low
  p_ready_stall_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_ready && !in_valid) |=> (in_ready && !sck));
  // R8: empty request finishes on the next cycle
  p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_IDLE && start && byte_cnt == '0) |=> done);
  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  // R9: error flag is only cleared by a new start
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (err && !(st_q == ST_IDLE && start)) |=> err);
  // R12: frames are separated by idle time
  p_gap_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ce_n) |=> ce_n);
endmodule

// File: tb/test_aai_prog_seq.sv
module test_aai_prog_seq;
  localparam int CW  = 16;
  localparam int DW  = 8;
  localparam int GAP = 4;
  localparam int TBP = 300;
  localparam int TMO = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0, use_poll = 1'b0, in_valid = 1'b0, so = 1'b0;
  logic [DW-1:0] clk_div = '0;
  logic [23:0]   start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [7:0]    in_data = '0;
  logic          in_ready, sck, ce_n, si, active, done, err;

  aai_prog_seq #(.CNT_W(CW), .DIV_W(DW), .GAP_CYC(GAP), .TBP_CYC(TBP),
                 .TMO_CYC(TMO), .TMR_W(16)) i_aai_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .use_poll(use_poll),
    .clk_div(clk_div), .start_addr(start_addr), .byte_cnt(byte_cnt),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sck(sck), .ce_n(ce_n), .si(si), .so(so), .active(active),
    .done(done), .err(err)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // flash model: records frames, answers status reads
  logic [7:0] fbyte [128][8];
  int flen [128];
  int t_fall [128];
  int t_rise [128];
  int sck_t [2];
  int nfr = 0, bitc = 0, busy_left = 0, busy_polls = 0;
  bit in_fr = 1'b0;
  logic [7:0] sr = '0;

  always @(negedge ce_n) begin
    in_fr = 1'b1;
    bitc  = 0;
    so    = 1'b0;
    if (nfr < 128) t_fall[nfr] = int'($time / 8);
  end

  always @(posedge sck) if (!ce_n && in_fr) begin
    sr = {sr[6:0], si};
    bitc++;
    if (nfr == 0 && bitc <= 2) sck_t[bitc-1] = int'($time / 8);
    if (bitc % 8 == 0 && bitc <= 64 && nfr < 128) fbyte[nfr][bitc/8-1] = sr;
  end

  always @(negedge sck) if (!ce_n && in_fr && nfr < 128) begin
    if (bitc >= 8 && bitc < 16 && fbyte[nfr][0] == 8'h05)
      so = (bitc == 15) ? (busy_left > 0) : 1'b0;
  end

  always @(posedge ce_n) if (in_fr) begin
    in_fr = 1'b0;
    if (nfr < 128) begin
      flen[nfr]   = bitc / 8;
      t_rise[nfr] = int'($time / 8);
      if (fbyte[nfr][0] == 8'hAF || fbyte[nfr][0] == 8'h04) busy_left = busy_polls;
      else if (fbyte[nfr][0] == 8'h05 && busy_left > 0) busy_left--;
    end
    nfr++;
  end

  // data source
  logic [7:0] src [16];
  int feed_n = 0, feed_i = 0, feed_dly = 0, stall = 0, t_done = 0;
  bit acc = 1'b0;

  always @(posedge clk) acc <= in_valid && in_ready;

  always @(negedge clk) begin
    if (acc) begin
      feed_i++;
      in_valid = 1'b0;
      stall = feed_dly;
    end else if (stall > 0) stall--;
    else if (feed_i < feed_n) begin
      in_valid = 1'b1;
      in_data  = src[feed_i];
    end
  end

  task automatic run(logic [23:0] a, int n, bit poll, int div, int dly, int bp);
    bit seen;
    @(negedge clk);
    nfr = 0; busy_polls = bp; busy_left = 0;
    for (int i = 0; i < 16; i++) src[i] = 8'h3C ^ 8'(i * 29);
    feed_n = n; feed_i = 0; feed_dly = dly; stall = dly;
    start_addr = a; byte_cnt = CW'(n); use_poll = poll; clk_div = DW'(div);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 60000; k++) begin
      if (done) begin seen = 1'b1; t_done = int'($time / 8); break; end
      @(negedge clk);
    end
    check("R7 done pulse seen", int'(seen), 1);
  endtask

  task automatic exp_fr(string tag, int k, int len, logic [7:0] b0,
                        logic [7:0] b1 = 0, logic [7:0] b2 = 0,
                        logic [7:0] b3 = 0, logic [7:0] b4 = 0);
    logic [7:0] e [5];
    e = '{b0, b1, b2, b3, b4};
    check($sformatf("%s frame %0d length", tag, k), flen[k], len);
    for (int i = 0; i < len; i++)
      check($sformatf("%s frame %0d byte %0d", tag, k, i), int'(fbyte[k][i]), int'(e[i]));
  endtask

  task automatic t_reset();
    check("R1 ce_n in reset", int'(ce_n), 1);
    check("R1 sck in reset", int'(sck), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ce_n after reset", int'(ce_n), 1);
    check("R1 sck after reset", int'(sck), 0);
    check("R1 err after reset", int'(err), 0);
    check("R1 in_ready after reset", int'(in_ready), 0);
    check("R1 active after reset", int'(active), 0);
  endtask

  task automatic t_zero();
    run(24'h000010, 0, 1'b1, 1, 0, 0);
    check("R8 no frames for zero count", nfr, 0);
    @(negedge clk);
    check("R7 done single cycle", int'(done), 0);
  endtask

  task automatic t_poll();
    int k;
    run(24'h123456, 3, 1'b1, 1, 0, 2);
    check("R5 total frames", nfr, 17);
    check("R10 sck period", sck_t[1] - sck_t[0], 4);
    exp_fr("R2", 0, 1, 8'h06);
    exp_fr("R3", 1, 5, 8'hAF, 8'h12, 8'h34, 8'h56, src[0]);
    for (int j = 2; j < 5; j++) exp_fr("R5", j, 2, 8'h05, 8'h00);
    exp_fr("R4", 5, 2, 8'hAF, src[1]);
    for (int j = 6; j < 9; j++) exp_fr("R5", j, 2, 8'h05, 8'h00);
    exp_fr("R4", 9, 2, 8'hAF, src[2]);
    exp_fr("R7", 13, 1, 8'h04);
    for (int j = 14; j < 17; j++) exp_fr("R5", j, 2, 8'h05, 8'h00);
    k = 0;
    for (int j = 0; j < 16; j++) if (t_fall[j+1] - t_rise[j] < GAP) k++;
    check("R12 short gaps", k, 0);
    check("R9 no error in normal run", int'(err), 0);
  endtask

  task automatic t_fixed();
    run(24'hABCDEF, 2, 1'b0, 2, 6, 0);
    check("R6 frames without status reads", nfr, 4);
    check("R10 sck period div 2", sck_t[1] - sck_t[0], 6);
    exp_fr("R2", 0, 1, 8'h06);
    exp_fr("R3 R11", 1, 5, 8'hAF, 8'hAB, 8'hCD, 8'hEF, src[0]);
    exp_fr("R4 R11", 2, 2, 8'hAF, src[1]);
    exp_fr("R7", 3, 1, 8'h04);
    check("R6 wait after first program", int'(t_fall[2] - t_rise[1] >= TBP), 1);
    check("R6 wait after second program", int'(t_fall[3] - t_rise[2] >= TBP), 1);
    check("R6 wait after write-disable", int'(t_done - t_rise[3] >= TBP), 1);
  endtask

  task automatic t_timeout();
    int naf;
    run(24'h000100, 2, 1'b1, 1, 0, 1000000);
    check("R9 err set", int'(err), 1);
    naf = 0;
    for (int j = 0; j < nfr && j < 128; j++) if (fbyte[j][0] == 8'hAF && flen[j] > 0) naf++;
    check("R9 no further program frame", naf, 1);
    check("R9 polls were issued", int'(fbyte[2][0]), 8'h05);
    exp_fr("R9", nfr - 1, 1, 8'h04);
    repeat (5) @(negedge clk);
    check("R9 err held", int'(err), 1);
    check("R9 ce_n idle", int'(ce_n), 1);
    run(24'h000000, 0, 1'b1, 1, 0, 0);
    check("R9 err cleared by start", int'(err), 0);
    check("R8 zero count no frames", nfr, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_zero();
    t_poll();
    t_fixed();
    t_timeout();
    summary();
    $finish;
  end
endmodule